// File: doc/BRIEF.md
# Debug Scan Chain for Coprocessor Register Access

This block is a test-data register that a JTAG TAP controller places between TDI and TDO. An external debugger uses it to read and write a small bank of 32-bit coprocessor control registers while the core is halted. The TAP controller itself is not part of the block. It supplies Capture-DR, Shift-DR and Update-DR strobes. It also supplies a select line, which is high when this chain is the chosen scan chain and the instruction register holds the internal-test instruction. All logic is clocked by TCK.

Each DR scan moves a 48-bit frame through the chain. On Update-DR, a frame that asks for an access and arrives while nothing is in flight posts a transfer to the core side. The transfer is held on a req/ack port until the core acknowledges it. On that acknowledge a write is committed to the register bank, or read data is taken from it. The debugger then polls with no-op frames. Every Capture-DR loads the completion flag into the frame, and for a finished read it also loads the read value. Bits 0, 2 and 12 of the control register are brought out as enables for address translation, the data cache and the instruction cache.

Top module: `cpreg_scan_port`

## Requirements
- R1: The frame is 48 bits and is shifted LSB first from TDI. Bits [31:0] hold the data word, bit 32 holds the access/ready flag, bits [46:33] hold the register address and bit 47 holds the direction (1 = write, 0 = read). TDO always presents frame bit 0.
- R2: On Capture-DR the frame is loaded as follows: bit 32 takes the ready flag, bits [31:0] take the result of the last completed read (zero after a write or while a transfer is pending), and bits [47:33] take zero.
- R3: An Update-DR with frame bit 32 = 1 while no transfer is pending raises core_req in the next cycle. From that frame, core_addr takes the address, core_we the direction and core_wdata the data. The ready flag reads 0 from that Update-DR until the acknowledge.
- R4: An Update-DR with frame bit 32 = 0 is a no-op. It starts no transfer and changes no register.
- R5: An access frame that arrives while a transfer is pending is ignored. core_addr, core_we and core_wdata keep the values of the pending transfer, and only that transfer completes.
- R6: A core_ack seen while core_req is high completes the transfer. core_req falls and the ready flag becomes 1 in the next cycle. The ready flag then stays 1 until the next accepted access.
- R7: The address packs op1 in bits [13:11], op2 in [10:8], a primary register number in [7:4] and a secondary number in [3:0]. Six registers are mapped: 0x0010 (control), 0x0020, 0x0050, 0x0150, 0x0060 and 0x38F0. Any other address completes normally, reads as zero and ignores writes.
- R8: mmu_en, dcache_en and icache_en follow bits 0, 2 and 12 of the control register at 0x0010.
- R9: While chain_sel is low, the Capture-DR, Shift-DR and Update-DR strobes have no effect.
- R10: A low rst_n at a clock edge clears the shift register, the pending transfer, the ready flag, the read result and all mapped registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock (TCK) |
| rst_n | input | 1 | Synchronous active-low reset (test reset) |
| chain_sel | input | 1 | This chain is selected and the internal-test instruction is loaded |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| core_ack | input | 1 | Core side has accepted the posted transfer |
| core_req | output | 1 | A transfer is posted and waiting for core_ack |
| core_we | output | 1 | Direction of the posted transfer, 1 = write |
| core_addr | output | 14 | Packed register address of the posted transfer |
| core_wdata | output | 32 | Write data of the posted transfer |
| mmu_en | output | 1 | Control register bit 0 |
| dcache_en | output | 1 | Control register bit 2 |
| icache_en | output | 1 | Control register bit 12 |

## Verification
The bench runs the post-then-poll sequence with core acknowledge latencies of zero, three and two hundred cycles. Only the long latency leaves a poll frame that captures ready = 0. It also places a second access inside the open window, which shows whether that access is dropped or replaces the first. Reads back to back from addresses that differ only in op1 or only in op2, plus an all-ones write to an unmapped address, show whether the whole 14-bit address is decoded. Frames with the access bit clear and frames shifted with chain_sel low are each followed by a readback of the control register, which separates ignored stimulus from stimulus with a hidden effect. A reset during a pending transfer checks that nothing from before the reset survives it.

// File: rtl/cpreg_pkg.sv
// Shared constants for the coprocessor register scan chain.
// Assumes the 14-bit packed address layout {op1[2:0], op2[2:0], rn[3:0], rm[3:0]}.
package cpreg_pkg;
    localparam int ADDR_W    = 14;
    localparam int NUM_REGS  = 6;
    localparam int CTRL_IDX  = 0;
    localparam int MMU_BIT   = 0;
    localparam int DCACHE_BIT = 2;
    localparam int ICACHE_BIT = 12;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    // Mapped addresses; index CTRL_IDX is the control register.
    localparam reg_addr_t REG_MAP [NUM_REGS] = '{
        14'h0010,   // op1=0 op2=0 rn=1  rm=0 : control
        14'h0020,   // op1=0 op2=0 rn=2  rm=0 : table base
        14'h0050,   // op1=0 op2=0 rn=5  rm=0 : data fault status
        14'h0150,   // op1=0 op2=1 rn=5  rm=0 : instruction fault status
        14'h0060,   // op1=0 op2=0 rn=6  rm=0 : fault address
        14'h38F0    // op1=7 op2=0 rn=15 rm=0 : cache debug control
    };
endpackage

// File: rtl/cpreg_shift.sv
// Frame shift register for the scan chain.
// Assumes the strobes are already qualified by chain select and are one-hot.
// Frame: [DATA_W-1:0] data, [DATA_W] access/ready, then address, then direction on top.
module cpreg_shift
    import cpreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              shf_en,
    input  logic              tdi,
    input  logic              cap_ready,
    input  logic [DATA_W-1:0] cap_data,
    output logic              tdo,
    output logic              frm_acc,
    output logic              frm_rw,
    output reg_addr_t         frm_addr,
    output logic [DATA_W-1:0] frm_data
);
    localparam int FRAME_W = DATA_W + ADDR_W + 2;
    localparam int ACC_POS = DATA_W;
    localparam int ADR_LO  = DATA_W + 1;

    logic [FRAME_W-1:0] sr;

    // Load status on capture, move one bit toward TDO on shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (cap_en)
            sr <= {1'b0, {ADDR_W{1'b0}}, cap_ready, cap_data};
        else if (shf_en)
            sr <= {tdi, sr[FRAME_W-1:1]};
    end

    assign tdo      = sr[0];
    assign frm_data = sr[DATA_W-1:0];
    assign frm_acc  = sr[ACC_POS];
    assign frm_addr = sr[ADR_LO +: ADDR_W];
    assign frm_rw   = sr[FRAME_W-1];

    // R2: TDO shows the captured ready-bit neighbour only after a full data field; here bit 0 after capture.
    assert_capture_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (tdo == $past(cap_data[0])));
endmodule

// File: rtl/cpreg_xfer.sv
// Posted-transfer tracker: accepts an access on Update-DR, holds it on the
// req/ack core port, and records completion and read data.
// Assumes core_ack is only meaningful while core_req is high.
module cpreg_xfer
    import cpreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              frm_acc,
    input  logic              frm_rw,
    input  reg_addr_t         frm_addr,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              core_ack,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic              core_req,
    output logic              core_we,
    output reg_addr_t         core_addr,
    output logic [DATA_W-1:0] core_wdata,
    output logic              bank_wr,
    output logic              ready,
    output logic [DATA_W-1:0] rd_result
);
    logic pending;
    logic launch;
    logic finish;

    assign launch = upd_en && frm_acc && !pending;
    assign finish = pending && core_ack;

    // Track the one outstanding transfer and its outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            ready      <= 1'b0;
            core_we    <= 1'b0;
            core_addr  <= '0;
            core_wdata <= '0;
            rd_result  <= '0;
        end else if (finish) begin
            pending <= 1'b0;
            ready   <= 1'b1;
            if (!core_we)
                rd_result <= bank_rdata;
        end else if (launch) begin
            pending    <= 1'b1;
            ready      <= 1'b0;
            core_we    <= frm_rw;
            core_addr  <= frm_addr;
            core_wdata <= frm_data;
            rd_result  <= '0;
        end
    end

    assign core_req = pending;
    assign bank_wr  = finish && core_we;

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_req && !core_ack |=> core_req);
    assert_not_ready_while_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> !ready);
    assert_noop_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !frm_acc && !core_req |=> !core_req);
    assert_pending_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_req && !core_ack |=> $stable(core_addr) && $stable(core_wdata) && $stable(core_we));
    assert_ready_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_req && core_ack |=> ready && !core_req);
endmodule

// File: rtl/cpreg_bank.sv
// Register bank behind the core port: decodes the packed address against the
// map in the package; unmapped addresses read zero and drop writes.
// Assumes wr_en is a single-cycle commit strobe.
module cpreg_bank
    import cpreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_addr_t         addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_q
);
    logic [NUM_REGS-1:0]             hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] masked;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        logic [DATA_W-1:0] val;
        assign hit[gi] = (addr == REG_MAP[gi]);
        // Store one mapped register on a matching commit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val <= '0;
            else if (wr_en && hit[gi])
                val <= wdata;
        end
        assign masked[gi] = hit[gi] ? val : '0;
    end

    // Merge the selected register onto the read bus.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            rdata = rdata | masked[i];
    end

    assign ctrl_q = g_reg[CTRL_IDX].val;

    assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (hit == '0) |=> $stable(ctrl_q));
    assert_one_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/cpreg_scan_port.sv
// Top of the coprocessor register scan chain: gates TAP strobes with the
// chain select, wires the frame register, transfer tracker and register bank,
// and exports the control-register enables.
// Assumes all inputs are synchronous to clk (TCK).
module cpreg_scan_port
    import cpreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_sel,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic              core_ack,
    output logic              core_req,
    output logic              core_we,
    output logic [ADDR_W-1:0] core_addr,
    output logic [DATA_W-1:0] core_wdata,
    output logic              mmu_en,
    output logic              dcache_en,
    output logic              icache_en
);
    logic              cap_en, shf_en, upd_en;
    logic              frm_acc, frm_rw;
    reg_addr_t         frm_addr;
    logic [DATA_W-1:0] frm_data;
    logic              ready, bank_wr;
    logic [DATA_W-1:0] rd_result, bank_rdata, ctrl_q;

    assign cap_en = chain_sel && capture_dr;
    assign shf_en = chain_sel && shift_dr;
    assign upd_en = chain_sel && update_dr;

    cpreg_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en), .tdi(tdi),
        .cap_ready(ready), .cap_data(rd_result), .tdo(tdo),
        .frm_acc(frm_acc), .frm_rw(frm_rw), .frm_addr(frm_addr), .frm_data(frm_data)
    );

    cpreg_xfer #(.DATA_W(DATA_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .frm_acc(frm_acc),
        .frm_rw(frm_rw), .frm_addr(frm_addr), .frm_data(frm_data),
        .core_ack(core_ack), .bank_rdata(bank_rdata), .core_req(core_req),
        .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
        .bank_wr(bank_wr), .ready(ready), .rd_result(rd_result)
    );

    cpreg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(bank_wr), .addr(core_addr),
        .wdata(core_wdata), .rdata(bank_rdata), .ctrl_q(ctrl_q)
    );

    assign mmu_en    = ctrl_q[MMU_BIT];
    assign dcache_en = ctrl_q[DCACHE_BIT];
    assign icache_en = ctrl_q[ICACHE_BIT];

    assert_unselected_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_sel && !core_req |=> !core_req);
    assert_enables_need_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr |=> $stable({mmu_en, dcache_en, icache_en}));
endmodule

// File: tb/sim_cpreg_scan_port.sv
module sim_cpreg_scan_port;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 14;
    localparam int FW = DW + AW + 2;

    logic clk = 1'b0, rst_n = 1'b0, chain_sel = 1'b1;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic core_ack = 1'b0;
    logic tdo, core_req, core_we, mmu_en, dcache_en, icache_en;
    logic [AW-1:0] core_addr;
    logic [DW-1:0] core_wdata;

    int n_checks = 0;
    int n_fail = 0;
    int ack_delay = 0;
    int ack_cnt = 0;
    bit done = 0;

    logic [DW:0] exp_q[$];
    logic [DW:0] act_q[$];
    string       tag_q[$];
    event        act_ev;

    cpreg_scan_port u0 (
        .clk(clk), .rst_n(rst_n), .chain_sel(chain_sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .core_ack(core_ack), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .mmu_en(mmu_en), .dcache_en(dcache_en), .icache_en(icache_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Core-side model: acknowledges a request after ack_delay cycles.
    always @(negedge clk) begin
        if (core_req && !core_ack) begin
            if (ack_cnt >= ack_delay) begin
                core_ack <= 1'b1;
                ack_cnt  <= 0;
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end else begin
            core_ack <= 1'b0;
            ack_cnt  <= 0;
        end
    end

    // Scoreboard monitor: compares captured frames against expectations.
    initial begin
        forever begin
            @(act_ev);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [DW:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual ready=%0b data=%h expected ready=%0b data=%h",
                             t, a[DW], a[DW-1:0], e[DW], e[DW-1:0]);
                end
            end
        end
    end

    function automatic logic [FW-1:0] mkframe(input logic [DW-1:0] d, input logic acc,
                                              input logic [AW-1:0] a, input logic rw);
        return {rw, a, acc, d};
    endfunction

    task automatic scan(input logic [FW-1:0] f, output logic [FW-1:0] cap);
        @(negedge clk);
        capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0;
        shift_dr   = 1'b1;
        for (int i = 0; i < FW; i++) begin
            tdi    = f[i];
            cap[i] = tdo;
            @(negedge clk);
        end
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
    endtask

    task automatic launch(input logic [AW-1:0] a, input logic rw, input logic [DW-1:0] d);
        logic [FW-1:0] c;
        scan(mkframe(d, 1'b1, a, rw), c);
    endtask

    task automatic poll_expect(input logic rdy, input logic [DW-1:0] d, input string tag);
        logic [FW-1:0] c;
        exp_q.push_back({rdy, d});
        tag_q.push_back(tag);
        scan(mkframe('0, 1'b0, '0, 1'b0), c);
        act_q.push_back({c[DW], c[DW-1:0]});
        ->act_ev;
    endtask

    task automatic wait_ready_expect(input logic [DW-1:0] d, input string tag);
        logic [FW-1:0] c;
        for (int k = 0; k < 20; k++) begin
            scan(mkframe('0, 1'b0, '0, 1'b0), c);
            if (c[DW] === 1'b1) break;
        end
        poll_expect(1'b1, d, tag);
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_sim();
    end

    initial begin
        logic [FW-1:0] c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk({core_req, mmu_en, dcache_en, icache_en}, 0, "R10 outputs after reset");
        poll_expect(1'b0, '0, "R10 ready clear after reset");

        // R3 / R6 / R8: write control with latency 3
        ack_delay = 3;
        launch(14'h0010, 1'b1, 32'h0000_1005);
        chk({core_req, core_we, core_addr, core_wdata}, {1'b1, 1'b1, 14'h0010, 32'h0000_1005},
            "R3 posted write fields");
        wait_ready_expect('0, "R6 write completes, data zero");
        chk({mmu_en, dcache_en, icache_en}, 3'b111, "R8 enables from control bits");

        // R2 / R6: read control, latency 0
        ack_delay = 0;
        launch(14'h0010, 1'b0, '0);
        wait_ready_expect(32'h0000_1005, "R2 read of control");
        poll_expect(1'b1, 32'h0000_1005, "R6 ready holds until next access");

        // R5: second access while pending is dropped
        ack_delay = 200;
        launch(14'h0020, 1'b1, 32'h8000_0001);
        poll_expect(1'b0, '0, "R3 ready low while pending");
        launch(14'h0050, 1'b1, 32'hDEAD_BEEF);
        chk({core_req, core_we, core_addr, core_wdata}, {1'b1, 1'b1, 14'h0020, 32'h8000_0001},
            "R5 pending transfer kept");
        wait_ready_expect('0, "R5 first write completes");
        ack_delay = 0;
        launch(14'h0050, 1'b0, '0);
        wait_ready_expect('0, "R5 dropped write not stored");
        launch(14'h0020, 1'b0, '0);
        wait_ready_expect(32'h8000_0001, "R1 data field end bits");

        // R7: decode of op2, op1 and unmapped
        launch(14'h0150, 1'b1, 32'h0000_1234);
        wait_ready_expect('0, "R7 write op2=1 register");
        launch(14'h0150, 1'b0, '0);
        wait_ready_expect(32'h0000_1234, "R7 op2 decode");
        launch(14'h38F0, 1'b1, 32'h0000_0007);
        wait_ready_expect('0, "R7 write op1=7 register");
        launch(14'h00F0, 1'b0, '0);
        wait_ready_expect('0, "R7 op1 decode, op1=0 alias unmapped");
        launch(14'h38F0, 1'b0, '0);
        wait_ready_expect(32'h0000_0007, "R7 op1=7 readback");
        launch(14'h3FFF, 1'b1, 32'hFFFF_FFFF);
        wait_ready_expect('0, "R7 unmapped write completes");
        launch(14'h3FFF, 1'b0, '0);
        wait_ready_expect('0, "R7 unmapped read zero");
        chk({mmu_en, dcache_en, icache_en}, 3'b111, "R7 unmapped write leaves control");

        // R4: no-op frame with write fields set
        scan(mkframe(32'h0, 1'b0, 14'h0010, 1'b1), c);
        chk({63'd0, core_req}, 0, "R4 no-op starts nothing");
        chk({mmu_en, dcache_en, icache_en}, 3'b111, "R4 no-op keeps control");
        launch(14'h0010, 1'b0, '0);
        wait_ready_expect(32'h0000_1005, "R4 control unchanged after no-op");

        // R9: strobes ignored while unselected
        chain_sel = 1'b0;
        scan(mkframe(32'h0, 1'b1, 14'h0010, 1'b1), c);
        chk({63'd0, core_req}, 0, "R9 no request while unselected");
        chk({mmu_en, dcache_en, icache_en}, 3'b111, "R9 control kept while unselected");
        chain_sel = 1'b1;
        poll_expect(1'b1, 32'h0000_1005, "R9 status kept while unselected");

        // R10: reset during a pending transfer
        ack_delay = 200;
        launch(14'h0010, 1'b1, 32'h0);
        chk({63'd0, core_req}, 1, "R10 transfer pending before reset");
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({core_req, mmu_en, dcache_en, icache_en}, 0, "R10 reset clears pending and bank");
        poll_expect(1'b0, '0, "R10 ready clear after mid-transfer reset");
        ack_delay = 0;

        repeat (5) @(negedge clk);
        finish_sim();
    end
endmodule